// File: doc/BRIEF.md
# Protected Interrupt Vector Relocation Register

This block is the control register that decides where a small microcontroller core looks for its interrupt vector table. The table sits either at word address zero of program flash or at the first word of the boot-loader region at the top of flash. It outputs the table base and the word address of any vector entry. It also outputs an interrupt-block signal that the core ANDs into its interrupt acceptance logic. The block never touches the core's global interrupt-enable flag.

The select bit is guarded by a timed unlock. Software first sets a change-enable bit. It then has four clock cycles to write the new select value with change-enable written as zero. Interrupts are held off from the cycle the unlock starts. If the select write lands in the window, the hold lasts until the following instruction retires. If no select write arrives, the hold ends when the window expires. A boot-lock input additionally holds off interrupts while code runs in the application region and the vectors live in the boot region.

Top module: `vec_reloc_ctrl`

## Requirements
- R1: After reset the register reads 0x00, the vector base is 0 and the interrupt block is low.
- R2: With the select bit at 0 the vector base is 0. With it at 1 the base is FLASH_WORDS minus (256 << boot_size_i), which gives 0x3F00, 0x3E00, 0x3C00 and 0x3800 for codes 0 to 3 with 16384 flash words.
- R3: A write to the register at 0x35 with bit 0 clear updates the select bit (bit 1) only in the four cycles after the cycle in which bit 0 was written as 1. Such a write also clears change-enable. A write of bit 1 at any other time is ignored.
- R4: The interrupt block is high in the cycle that writes change-enable to 1 and stays high while change-enable is set.
- R5: If no select write arrives, change-enable and the interrupt block both drop after the fourth cycle following the enable write.
- R6: After an accepted select write, the interrupt block stays high up to and including the first cycle after the write cycle in which instr_done_i is high. It is low from the next cycle.
- R7: Writing change-enable to 1 while the window is open restarts the four-cycle window.
- R8: When the select bit is 1 and boot_lock_i is high, the interrupt block is high whenever pc_i is below the boot-region start. It is not high from this cause otherwise.
- R9: The register sits at address 0x35. Bit 7 (debug off) and bit 4 (pull-ups off) are read/write at any time and drive dbg_off_o and pullup_off_o. Bit 1 is select and bit 0 is change-enable. Bits 6, 5, 3 and 2 read as 0. Writes to other addresses have no effect.
- R10: vec_addr_o equals the vector base plus 2 * vec_num_i.
- R11: The vector base takes its new value in the cycle after an accepted select write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register-bus write strobe |
| addr_i | input | 6 | Register-bus I/O address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (0 when it does not match) |
| boot_size_i | input | 2 | Boot region size code |
| boot_lock_i | input | 1 | Boot-lock configuration |
| instr_done_i | input | 1 | Instruction-retire strobe |
| pc_i | input | 14 | Current program counter (word address) |
| vec_num_i | input | 5 | Interrupt number to translate |
| vec_base_o | output | 14 | Vector table base word address |
| vec_addr_o | output | 14 | Word address of entry vec_num_i |
| irq_block_o | output | 1 | Interrupt acceptance hold-off |
| dbg_off_o | output | 1 | Debug-disable register bit |
| pullup_off_o | output | 1 | Pull-up-disable register bit |

## Verification
The assertions check on every cycle that the select bit never changes unless change-enable was set one cycle before. They also check that the window counter stays in range, that the block is high whenever change-enable is set, and that the post-write hold ends after a retire strobe. Only the bench's scenarios show the exact window edges: a select write in the fourth cycle is accepted and one in the fifth is ignored. The bench scenarios also cover the restart of the window, the one-cycle delay of the vector base, and the boot-lock gating against the program counter for every boot size.

// File: rtl/vec_reloc_pkg.sv
package vec_reloc_pkg;
  localparam int unsigned BIT_DBG  = 7;
  localparam int unsigned BIT_PUD  = 4;
  localparam int unsigned BIT_SEL  = 1;
  localparam int unsigned BIT_CE   = 0;
  localparam int unsigned BOOT_MIN = 256;

  function automatic int unsigned boot_words(input logic [1:0] code);
    return BOOT_MIN << code;
  endfunction
endpackage

// File: rtl/vr_regfile.sv
module vr_regfile #(
  parameter int unsigned ADDR_W   = 6,
  parameter logic [5:0]  REG_ADDR = 6'h35
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              sel_i,
  input  logic              ce_i,
  output logic              reg_wr_o,
  output logic [7:0]        rdata_o,
  output logic              dbg_off_o,
  output logic              pullup_off_o
);
  import vec_reloc_pkg::*;

  logic hit;
  logic dbg_q, pud_q;
  logic unused_wdata;

  assign hit          = (addr_i == ADDR_W'(REG_ADDR));
  assign reg_wr_o     = we_i && hit;
  assign unused_wdata = ^{wdata_i[6:5], wdata_i[3:2]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_q <= 1'b0;
      pud_q <= 1'b0;
    end else if (reg_wr_o) begin
      dbg_q <= wdata_i[BIT_DBG];
      pud_q <= wdata_i[BIT_PUD];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit) begin
      rdata_o[BIT_DBG] = dbg_q;
      rdata_o[BIT_PUD] = pud_q;
      rdata_o[BIT_SEL] = sel_i;
      rdata_o[BIT_CE]  = ce_i;
    end
  end

  assign dbg_off_o    = dbg_q;
  assign pullup_off_o = pud_q;

  a_r9_no_write_off_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_o |=> $stable(dbg_q) && $stable(pud_q));
endmodule

// File: rtl/vr_unlock.sv
module vr_unlock #(
  parameter int unsigned WIN_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_wr_i,
  input  logic [7:0] wdata_i,
  input  logic       instr_done_i,
  output logic       sel_o,
  output logic       ce_o,
  output logic       hold_o
);
  import vec_reloc_pkg::*;

  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);

  logic             sel_q, ce_q, post_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ce_set, sel_wr;

  assign ce_set = reg_wr_i && wdata_i[BIT_CE];
  assign sel_wr = reg_wr_i && !wdata_i[BIT_CE] && ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= 1'b0;
      ce_q  <= 1'b0;
      cnt_q <= '0;
    end else if (ce_set) begin
      ce_q  <= 1'b1;
      cnt_q <= CNT_W'(WIN_CYC);
    end else if (sel_wr) begin
      sel_q <= wdata_i[BIT_SEL];
      ce_q  <= 1'b0;
      cnt_q <= '0;
    end else if (ce_q) begin
      if (cnt_q == CNT_W'(1)) ce_q <= 1'b0;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  // hold until the instruction after the select write retires
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    post_q <= 1'b0;
    else if (sel_wr)                post_q <= 1'b1;
    else if (post_q && instr_done_i) post_q <= 1'b0;
  end

  assign sel_o  = sel_q;
  assign ce_o   = ce_q;
  assign hold_o = ce_set || ce_q || post_q;

  a_r3_sel_needs_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_q) |-> $past(ce_q));
  a_r5_window_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(WIN_CYC)));
  a_r6_post_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (post_q && instr_done_i && !reg_wr_i) |=> !post_q);
endmodule

// File: rtl/vr_vector.sv
module vr_vector #(
  parameter int unsigned PC_W  = 14,
  parameter int unsigned NUM_W = 5
) (
  input  logic             sel_i,
  input  logic [1:0]       boot_size_i,
  input  logic             boot_lock_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [NUM_W-1:0] vec_num_i,
  output logic [PC_W-1:0]  vec_base_o,
  output logic [PC_W-1:0]  vec_addr_o,
  output logic             lock_hold_o
);
  import vec_reloc_pkg::*;

  localparam int unsigned FLASH_WORDS = 1 << PC_W;

  logic [PC_W:0]   start_ext;
  logic [PC_W-1:0] boot_start;

  assign start_ext   = (PC_W+1)'(FLASH_WORDS - boot_words(boot_size_i));
  assign boot_start  = start_ext[PC_W-1:0];
  assign vec_base_o  = sel_i ? boot_start : '0;
  assign vec_addr_o  = vec_base_o + {{(PC_W-NUM_W-1){1'b0}}, vec_num_i, 1'b0};
  assign lock_hold_o = sel_i && boot_lock_i && (pc_i < boot_start);
endmodule

// File: rtl/vec_reloc_ctrl.sv
module vec_reloc_ctrl #(
  parameter int unsigned ADDR_W   = 6,
  parameter logic [5:0]  REG_ADDR = 6'h35,
  parameter int unsigned PC_W     = 14,
  parameter int unsigned NUM_W    = 5,
  parameter int unsigned WIN_CYC  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [1:0]        boot_size_i,
  input  logic              boot_lock_i,
  input  logic              instr_done_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [NUM_W-1:0]  vec_num_i,
  output logic [PC_W-1:0]   vec_base_o,
  output logic [PC_W-1:0]   vec_addr_o,
  output logic              irq_block_o,
  output logic              dbg_off_o,
  output logic              pullup_off_o
);
  logic reg_wr, sel, ce, hold, lock_hold;

  vr_regfile #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .sel_i(sel), .ce_i(ce), .reg_wr_o(reg_wr),
    .rdata_o, .dbg_off_o, .pullup_off_o
  );

  vr_unlock #(.WIN_CYC(WIN_CYC)) u_unlock (
    .clk_i, .rst_ni, .reg_wr_i(reg_wr), .wdata_i, .instr_done_i,
    .sel_o(sel), .ce_o(ce), .hold_o(hold)
  );

  vr_vector #(.PC_W(PC_W), .NUM_W(NUM_W)) u_vec (
    .sel_i(sel), .boot_size_i, .boot_lock_i, .pc_i, .vec_num_i,
    .vec_base_o, .vec_addr_o, .lock_hold_o(lock_hold)
  );

  assign irq_block_o = hold || lock_hold;

  a_r4_block_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce |-> irq_block_o);
  a_r11_base_follows_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(sel) && $stable(boot_size_i) |-> $stable(vec_base_o));
endmodule

// File: tb/sim_vec_reloc_ctrl.sv
module sim_vec_reloc_ctrl;
  logic        clk = 0, rst_ni = 0;
  logic        we = 0, boot_lock = 0, instr_done = 0;
  logic [5:0]  addr = 6'h35;
  logic [7:0]  wdata = 0, rdata;
  logic [1:0]  boot_size = 2'd3;
  logic [13:0] pc = 0, base, vaddr;
  logic [4:0]  vnum = 0;
  logic        blk, dbg, pud;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  vec_reloc_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .boot_size_i(boot_size), .boot_lock_i(boot_lock),
    .instr_done_i(instr_done), .pc_i(pc), .vec_num_i(vnum),
    .vec_base_o(base), .vec_addr_o(vaddr), .irq_block_o(blk),
    .dbg_off_o(dbg), .pullup_off_o(pud)
  );

  function automatic int bstart(int code);
    return 16384 - (256 << code);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts and ends at a negedge; write takes effect at the posedge between
  task automatic wr(logic [5:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1;
    #1;
    @(negedge clk);
    we = 0; addr = 6'h35; wdata = 0;
    #1;
  endtask

  task automatic retire();
    instr_done = 1; #1;
    @(negedge clk);
    instr_done = 0; #1;
  endtask

  task automatic set_sel(logic s);
    wr(6'h35, 8'h01);
    wr(6'h35, {6'b0, s, 1'b0});
    retire();
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1 rdata", rdata, 0);
    chk("R1 base", base, 0);
    chk("R1 block", blk, 0);
    rst_ni = 1;
    @(negedge clk); #1;

    // R9 layout: write with bit0 clear outside window, reserved bits ignored
    wr(6'h35, 8'hFE);
    chk("R9 rw bits", rdata, 8'h90);
    chk("R9 dbg", dbg, 1);
    chk("R9 pud", pud, 1);
    chk("R3 sel ignored", base, 0);
    wr(6'h36, 8'h01);
    chk("R9 other addr no ce", blk, 0);
    chk("R9 other addr", rdata, 8'h90);
    wr(6'h35, 8'h00);
    chk("R9 cleared", rdata, 0);

    // window sweep: select write k cycles after enable
    for (int k = 1; k <= 5; k++) begin
      addr = 6'h35; wdata = 8'h01; we = 1; #1;
      chk("R4 block in ce cycle", blk, 1);
      @(negedge clk); we = 0; #1;
      chk("R4 ce reads 1", rdata[0], 1);
      for (int i = 1; i < k; i++) begin
        chk("R4 block in window", blk, 1);
        @(negedge clk); #1;
      end
      chk("R5 block at window edge", blk, k <= 4);
      chk("R5 ce at window edge", rdata[0], k <= 4);
      wdata = 8'h02; we = 1; #1;
      chk("R11 base before edge", base, 0);
      @(negedge clk); we = 0; wdata = 0; #1;
      chk("R3 sel accept", rdata, (k <= 4) ? 8'h02 : 8'h00);
      chk("R11 base after", base, (k <= 4) ? bstart(3) : 0);
      if (k <= 4) begin
        chk("R6 hold after write", blk, 1);
        @(negedge clk); #1;
        chk("R6 hold no retire", blk, 1);
        instr_done = 1; #1;
        chk("R6 hold in retire", blk, 1);
        @(negedge clk); instr_done = 0; #1;
        chk("R6 released", blk, 0);
        set_sel(0);
        chk("R3 sel back", base, 0);
      end else begin
        chk("R5 no hold", blk, 0);
      end
    end

    // R7 restart
    wr(6'h35, 8'h01);
    repeat (2) @(negedge clk);
    #1;
    wr(6'h35, 8'h01);
    repeat (3) @(negedge clk);
    #1;
    chk("R7 still open", rdata[0], 1);
    wr(6'h35, 8'h02);
    chk("R7 accepted", rdata[1], 1);
    retire();
    chk("R7 released", blk, 0);

    // R2/R10 sweep all boot sizes and vector numbers
    for (int c = 0; c < 4; c++) begin
      boot_size = 2'(c); #1;
      chk("R2 base", base, bstart(c));
      for (int n = 0; n < 32; n++) begin
        vnum = 5'(n); #1;
        chk("R10 entry", vaddr, bstart(c) + 2*n);
      end
      // R8 lock gating
      boot_lock = 1; pc = 14'(bstart(c) - 1); #1;
      chk("R8 app region", blk, 1);
      pc = 14'(bstart(c)); #1;
      chk("R8 boot region", blk, 0);
      pc = 0; boot_lock = 0; #1;
      chk("R8 unlocked", blk, 0);
    end
    set_sel(0);
    for (int n = 0; n < 32; n += 7) begin
      vnum = 5'(n); #1;
      chk("R10 entry low", vaddr, 2*n);
    end
    boot_lock = 1; pc = 0; #1;
    chk("R8 sel low", blk, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule